// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

Two agents share one synchronous word array through a left port and a right port. Each port can read or write any word in a cycle, with no arbitration between them. The top two words of the array also act as a doorbell pair. When one side writes its outgoing mailbox word, it raises an interrupt line toward the other side. When the receiving side reads that same word, the line drops again. A typical use is one processor placing a command block in the array, writing the top word, and letting the other processor's interrupt handler collect it.

The depth is 2 to the power `DEPTH_LOG2` words, and the stored width is `DATA_W` bits. The data buses are rounded up to whole bytes, and each byte has one enable bit. The address buses are `ADDR_W` bits wide, and any bits above the implemented depth are discarded. The 1K×8, 2K×8 and 2K×16 arrangements come from `DEPTH_LOG2` = 10/11/11 with `DATA_W` = 8/8/16. A separate peek address returns a word at once and never touches the doorbells. This lets a debugger inspect the array without side effects.

Top module: `dpmbox_ram`

## Requirements
- R1: While `rst_ni` is low, both interrupt outputs go low and every array word is cleared to zero.
- R2: A read (enable high, write-enable low) presents the addressed word on that port's read data one clock later. The read data otherwise keeps its last value.
- R3: Any left-port write to address DEPTH-1 sets `r_irq_o` at the next clock, whatever the byte enables.
- R4: A right-port read of address DEPTH-1 clears `r_irq_o` at the next clock.
- R5: Any right-port write to address DEPTH-2 sets `l_irq_o` at the next clock, whatever the byte enables.
- R6: A left-port read of address DEPTH-2 clears `l_irq_o` at the next clock.
- R7: Address bits at and above `DEPTH_LOG2` are ignored by data accesses, by mailbox decoding and by the peek address.
- R8: Byte enable bit k gates data bits 8k+7..8k. Write data bits at and above `DATA_W` are dropped, and read data returns zero in those positions.
- R9: `peek_data_o` shows the word at the masked `peek_addr_i` in the same cycle and never changes either interrupt.
- R10: `busy_o` is held at 0.
- R11: When both ports write one address in the same cycle, lanes enabled on the left take left data, lanes enabled only on the right take right data, and the rest keep their old value. A read by one port of an address the other port writes in the same cycle returns the old word.
- R12: If a mailbox word's set and clear happen in the same cycle, the interrupt ends up set.
- R13: A left read of DEPTH-1, a right write of DEPTH-1, a right read of DEPTH-2 and a left write of DEPTH-2 leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_en_i | input | 1 | Left access enable |
| l_we_i | input | 1 | Left write (1) or read (0) |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | BE_W*8 | Left write data |
| l_be_i | input | BE_W | Left byte enables |
| l_rdata_o | output | BE_W*8 | Left read data, registered |
| r_en_i | input | 1 | Right access enable |
| r_we_i | input | 1 | Right write (1) or read (0) |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | BE_W*8 | Right write data |
| r_be_i | input | BE_W | Right byte enables |
| r_rdata_o | output | BE_W*8 | Right read data, registered |
| l_irq_o | output | 1 | Interrupt toward the left side |
| r_irq_o | output | 1 | Interrupt toward the right side |
| peek_addr_i | input | ADDR_W | Side-effect-free peek address |
| peek_data_o | output | BE_W*8 | Peek word, combinational |
| busy_o | output | 1 | Arbitration busy, constant 0 |

BE_W is (DATA_W+7)/8.

## Verification
The bench builds the block with `DEPTH_LOG2` = 4, `DATA_W` = 12 and `ADDR_W` = 6. With only 16 words, every address, both mailbox words and every byte-enable pattern can be swept from both ports. Aliased addresses with all four upper-bit values reach the same words. The 12-bit width leaves four unused bits in the upper lane, so masking of write data and zero-filling of read data become visible at the ports.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/dpmb_port.sv
module dpmb_port
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AW     = 11,
  parameter int DATA_W = 8,
  parameter int BE_W   = 1
) (
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W*8-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output acc_e              acc_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] wmask_o
);
  localparam int BUS_W = BE_W * 8;

  always_comb begin
    if (!en_i)     acc_o = ACC_IDLE;
    else if (we_i) acc_o = ACC_WRITE;
    else           acc_o = ACC_READ;
  end

  assign addr_o  = addr_i[AW-1:0];
  assign wdata_o = wdata_i[DATA_W-1:0];

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign wmask_o[b] = be_i[b/8];
  end

  if (ADDR_W > AW) begin : g_addr_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[ADDR_W-1:AW];
  end
  if (BUS_W > DATA_W) begin : g_data_hi
    logic unused_data_hi;
    assign unused_data_hi = ^wdata_i[BUS_W-1:DATA_W];
  end
endmodule

// File: rtl/dpmb_array.sv
module dpmb_array
  import dpmb_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              l_acc_i,
  input  logic [AW-1:0]     l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic [DATA_W-1:0] l_wmask_i,
  input  acc_e              r_acc_i,
  input  logic [AW-1:0]     r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic [DATA_W-1:0] r_wmask_i,
  input  logic [AW-1:0]     peek_addr_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic [DATA_W-1:0] peek_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] r_new, l_base, l_new;
  logic              l_wr, r_wr;

  assign l_wr = (l_acc_i == ACC_WRITE);
  assign r_wr = (r_acc_i == ACC_WRITE);

  // left merges on top of the right result when both hit one word
  always_comb begin
    r_new  = (mem[r_addr_i] & ~r_wmask_i) | (r_wdata_i & r_wmask_i);
    l_base = (r_wr && (r_addr_i == l_addr_i)) ? r_new : mem[l_addr_i];
    l_new  = (l_base & ~l_wmask_i) | (l_wdata_i & l_wmask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      l_rdata_o <= '0;
      r_rdata_o <= '0;
    end else begin
      if (l_acc_i == ACC_READ) l_rdata_o <= mem[l_addr_i];
      if (r_acc_i == ACC_READ) r_rdata_o <= mem[r_addr_i];
      if (r_wr) mem[r_addr_i] <= r_new;
      if (l_wr) mem[l_addr_i] <= l_new;
    end
  end

  assign peek_data_o = mem[peek_addr_i];
endmodule

// File: rtl/dpmb_mailbox.sv
module dpmb_mailbox
  import dpmb_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_e          l_acc_i,
  input  logic [AW-1:0] l_addr_i,
  input  acc_e          r_acc_i,
  input  logic [AW-1:0] r_addr_i,
  output logic          l_irq_o,
  output logic          r_irq_o
);
  localparam logic [AW-1:0] BOX_TO_R = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_TO_L = {{(AW-1){1'b1}}, 1'b0};

  logic set_r, clr_r, set_l, clr_l;

  assign set_r = (l_acc_i == ACC_WRITE) && (l_addr_i == BOX_TO_R);
  assign clr_r = (r_acc_i == ACC_READ)  && (r_addr_i == BOX_TO_R);
  assign set_l = (r_acc_i == ACC_WRITE) && (r_addr_i == BOX_TO_L);
  assign clr_l = (l_acc_i == ACC_READ)  && (l_addr_i == BOX_TO_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_irq_o <= 1'b0;
      r_irq_o <= 1'b0;
    end else begin
      if (set_r)      r_irq_o <= 1'b1;
      else if (clr_r) r_irq_o <= 1'b0;
      if (set_l)      l_irq_o <= 1'b1;
      else if (clr_l) l_irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dpmbox_ram.sv
module dpmbox_ram
  import dpmb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DEPTH_LOG2 = 11,
  parameter int DATA_W     = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            l_en_i,
  input  logic                            l_we_i,
  input  logic [ADDR_W-1:0]               l_addr_i,
  input  logic [((DATA_W+7)/8)*8-1:0]     l_wdata_i,
  input  logic [(DATA_W+7)/8-1:0]         l_be_i,
  output logic [((DATA_W+7)/8)*8-1:0]     l_rdata_o,
  input  logic                            r_en_i,
  input  logic                            r_we_i,
  input  logic [ADDR_W-1:0]               r_addr_i,
  input  logic [((DATA_W+7)/8)*8-1:0]     r_wdata_i,
  input  logic [(DATA_W+7)/8-1:0]         r_be_i,
  output logic [((DATA_W+7)/8)*8-1:0]     r_rdata_o,
  output logic                            l_irq_o,
  output logic                            r_irq_o,
  input  logic [ADDR_W-1:0]               peek_addr_i,
  output logic [((DATA_W+7)/8)*8-1:0]     peek_data_o,
  output logic                            busy_o
);
  localparam int BE_W  = (DATA_W + 7) / 8;
  localparam int BUS_W = BE_W * 8;
  localparam int AW    = DEPTH_LOG2;

  acc_e              l_acc, r_acc;
  logic [AW-1:0]     l_addr, r_addr;
  logic [DATA_W-1:0] l_wdata, r_wdata, l_wmask, r_wmask;
  logic [DATA_W-1:0] l_rdata, r_rdata, peek_data;

  dpmb_port #(.ADDR_W(ADDR_W), .AW(AW), .DATA_W(DATA_W), .BE_W(BE_W)) i_port_l (
    .en_i(l_en_i), .we_i(l_we_i), .addr_i(l_addr_i), .wdata_i(l_wdata_i),
    .be_i(l_be_i), .acc_o(l_acc), .addr_o(l_addr), .wdata_o(l_wdata),
    .wmask_o(l_wmask)
  );

  dpmb_port #(.ADDR_W(ADDR_W), .AW(AW), .DATA_W(DATA_W), .BE_W(BE_W)) i_port_r (
    .en_i(r_en_i), .we_i(r_we_i), .addr_i(r_addr_i), .wdata_i(r_wdata_i),
    .be_i(r_be_i), .acc_o(r_acc), .addr_o(r_addr), .wdata_o(r_wdata),
    .wmask_o(r_wmask)
  );

  dpmb_array #(.AW(AW), .DATA_W(DATA_W)) i_array (
    .clk_i, .rst_ni,
    .l_acc_i(l_acc), .l_addr_i(l_addr), .l_wdata_i(l_wdata), .l_wmask_i(l_wmask),
    .r_acc_i(r_acc), .r_addr_i(r_addr), .r_wdata_i(r_wdata), .r_wmask_i(r_wmask),
    .peek_addr_i(peek_addr_i[AW-1:0]),
    .l_rdata_o(l_rdata), .r_rdata_o(r_rdata), .peek_data_o(peek_data)
  );

  dpmb_mailbox #(.AW(AW)) i_mailbox (
    .clk_i, .rst_ni,
    .l_acc_i(l_acc), .l_addr_i(l_addr), .r_acc_i(r_acc), .r_addr_i(r_addr),
    .l_irq_o, .r_irq_o
  );

  assign l_rdata_o   = BUS_W'(l_rdata);
  assign r_rdata_o   = BUS_W'(r_rdata);
  assign peek_data_o = BUS_W'(peek_data);
  assign busy_o      = 1'b0;

  if (ADDR_W > AW) begin : g_peek_hi
    logic unused_peek_hi;
    assign unused_peek_hi = ^peek_addr_i[ADDR_W-1:AW];
  end
endmodule

// File: rtl/dpmb_checker.sv
module dpmb_checker #(
  parameter int ADDR_W     = 16,
  parameter int DEPTH_LOG2 = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_en_i,
  input logic              l_we_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              r_en_i,
  input logic              r_we_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              l_irq_o,
  input logic              r_irq_o
);
  localparam logic [DEPTH_LOG2-1:0] TOP  = {DEPTH_LOG2{1'b1}};
  localparam logic [DEPTH_LOG2-1:0] TOP1 = TOP - 1'b1;

  logic [DEPTH_LOG2-1:0] la, ra;
  logic l_wr_top, r_rd_top, r_wr_top1, l_rd_top1;

  assign la        = l_addr_i[DEPTH_LOG2-1:0];
  assign ra        = r_addr_i[DEPTH_LOG2-1:0];
  assign l_wr_top  = l_en_i && l_we_i && (la == TOP);
  assign r_rd_top  = r_en_i && !r_we_i && (ra == TOP);
  assign r_wr_top1 = r_en_i && r_we_i && (ra == TOP1);
  assign l_rd_top1 = l_en_i && !l_we_i && (la == TOP1);

  if (ADDR_W > DEPTH_LOG2) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^{l_addr_i[ADDR_W-1:DEPTH_LOG2], r_addr_i[ADDR_W-1:DEPTH_LOG2]};
  end

  assert_r_irq_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_wr_top |=> r_irq_o);
  assert_r_irq_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_rd_top && !l_wr_top |=> !r_irq_o);
  assert_l_irq_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_wr_top1 |=> l_irq_o);
  assert_l_irq_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rd_top1 && !r_wr_top1 |=> !l_irq_o);
  assert_set_beats_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_wr_top && r_rd_top |=> r_irq_o);
  assert_r_irq_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_wr_top && !r_rd_top |=> $stable(r_irq_o));
  assert_l_irq_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_wr_top1 && !l_rd_top1 |=> $stable(l_irq_o));
endmodule

bind dpmbox_ram dpmb_checker #(.ADDR_W(ADDR_W), .DEPTH_LOG2(DEPTH_LOG2)) i_dpmb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_en_i(l_en_i), .l_we_i(l_we_i), .l_addr_i(l_addr_i),
  .r_en_i(r_en_i), .r_we_i(r_we_i), .r_addr_i(r_addr_i),
  .l_irq_o(l_irq_o), .r_irq_o(r_irq_o)
);

// File: tb/test_dpmbox_ram.sv
module test_dpmbox_ram;
  localparam int ADDR_W = 6;
  localparam int DL2    = 4;
  localparam int DW     = 12;
  localparam int BEW    = 2;
  localparam int BW     = 16;
  localparam int DEPTH  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic l_en_i = 0, l_we_i = 0, r_en_i = 0, r_we_i = 0;
  logic [ADDR_W-1:0] l_addr_i = '0, r_addr_i = '0, peek_addr_i = '0;
  logic [BW-1:0] l_wdata_i = '0, r_wdata_i = '0;
  logic [BEW-1:0] l_be_i = '0, r_be_i = '0;
  logic [BW-1:0] l_rdata_o, r_rdata_o, peek_data_o;
  logic l_irq_o, r_irq_o, busy_o;

  dpmbox_ram #(.ADDR_W(ADDR_W), .DEPTH_LOG2(DL2), .DATA_W(DW)) i_dpmbox_ram (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] em [DEPTH];
  logic [BW-1:0] e_lrd = '0, e_rrd = '0;
  logic e_lirq = 0, e_rirq = 0;

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [BW-1:0] wd, logic [BEW-1:0] be);
    logic [DW-1:0] r = old;
    for (int i = 0; i < DW; i++) if (be[i/8]) r[i] = wd[i];
    return r;
  endfunction

  // one cycle, driven at negedge, checked at the following negedge
  task automatic step(input logic le, lw, input logic [ADDR_W-1:0] la, input logic [BW-1:0] lwd,
                      input logic [BEW-1:0] lbe, input logic re, rw, input logic [ADDR_W-1:0] ra,
                      input logic [BW-1:0] rwd, input logic [BEW-1:0] rbe, input string req);
    logic [DL2-1:0] lm, rm;
    logic [DW-1:0] rnew;
    lm = la[DL2-1:0];
    rm = ra[DL2-1:0];
    l_en_i = le; l_we_i = lw; l_addr_i = la; l_wdata_i = lwd; l_be_i = lbe;
    r_en_i = re; r_we_i = rw; r_addr_i = ra; r_wdata_i = rwd; r_be_i = rbe;
    if (le && !lw) e_lrd = BW'(em[lm]);
    if (re && !rw) e_rrd = BW'(em[rm]);
    if (le && lw && lm == 4'd15) e_rirq = 1;
    else if (re && !rw && rm == 4'd15) e_rirq = 0;
    if (re && rw && rm == 4'd14) e_lirq = 1;
    else if (le && !lw && lm == 4'd14) e_lirq = 0;
    if (re && rw) begin
      rnew = merge(em[rm], rwd, rbe);
      em[rm] = rnew;
    end
    if (le && lw) em[lm] = merge(em[lm], lwd, lbe);
    @(posedge clk_i);
    @(negedge clk_i);
    l_en_i = 0; r_en_i = 0;
    check({req, " l_rdata"}, l_rdata_o, e_lrd);
    check({req, " r_rdata"}, r_rdata_o, e_rrd);
    check({req, " l_irq"}, BW'(l_irq_o), BW'(e_lirq));
    check({req, " r_irq"}, BW'(r_irq_o), BW'(e_rirq));
  endtask

  task automatic idle(input string req);
    step(0, 0, '0, '0, '0, 0, 0, '0, '0, '0, req);
  endtask

  task automatic peek_chk(input logic [ADDR_W-1:0] a, input string req);
    peek_addr_i = a;
    #1;
    check(req, peek_data_o, BW'(em[a[DL2-1:0]]));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) em[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 l_irq", BW'(l_irq_o), '0);
    check("R1 r_irq", BW'(r_irq_o), '0);
    rst_ni = 1;
    @(negedge clk_i);
    for (int a = 0; a < 64; a++) peek_chk(6'(a), "R1 cleared/R7 peek alias");
    check("R10 busy", BW'(busy_o), '0);

    // R8/R3: full-width left fill, upper data bits must be dropped
    for (int a = 0; a < DEPTH; a++)
      step(1, 1, 6'(a), 16'hF000 | 16'(a * 16'h137 + 16'h5A), 2'b11, 0, 0, '0, '0, '0, "R8 fill");
    // R2/R4: right read sweep, last one clears r_irq
    for (int a = 0; a < DEPTH; a++)
      step(0, 0, '0, '0, '0, 1, 0, 6'(a), '0, '0, "R2 right read");
    // R7: left reads through every alias
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < DEPTH; a++)
        step(1, 0, 6'(k * 16 + a), '0, '0, 0, 0, '0, '0, '0, "R7 alias read");

    // R8: every byte-enable pattern from the right, read back on the left
    for (int a = 0; a < DEPTH; a++)
      for (int be = 0; be < 4; be++) begin
        step(0, 0, '0, '0, '0, 1, 1, 6'(a), ~16'(a * 16'h2B1 + be), 2'(be), "R8 lanes");
        step(1, 0, 6'(a), '0, '0, 0, 0, '0, '0, '0, "R8 lanes readback");
        peek_chk(6'(a + 32), "R9 peek");
      end
    idle("R6 drain");

    // mailbox directed cases
    step(1, 1, 6'd15, 16'h0ABC, 2'b00, 0, 0, '0, '0, '0, "R3 set no lanes");
    step(1, 0, 6'd15, '0, '0, 0, 0, '0, '0, '0, "R13 left read top");
    step(0, 0, '0, '0, '0, 1, 1, 6'd15, 16'h0123, 2'b11, "R13 right write top");
    step(0, 0, '0, '0, '0, 1, 0, 6'd14, '0, '0, "R13 right read top-1");
    step(1, 1, 6'd14, 16'h0456, 2'b11, 0, 0, '0, '0, '0, "R13 left write top-1");
    check("R13 l_irq stays low", BW'(l_irq_o), '0);
    check("R13 r_irq stays high", BW'(r_irq_o), 16'd1);
    step(0, 0, '0, '0, '0, 1, 0, 6'd15, '0, '0, "R4 clear");
    check("R4 r_irq low", BW'(r_irq_o), '0);
    step(0, 0, '0, '0, '0, 1, 1, 6'd46, 16'h0777, 2'b01, "R5 set via alias");
    check("R5 l_irq high", BW'(l_irq_o), 16'd1);
    for (int a = 0; a < 8; a++) peek_chk(6'(a + 8), "R9 peek leaves irq");
    peek_chk(6'd14, "R9 peek mailbox");
    idle("R9 irq unchanged");
    step(1, 0, 6'd62, '0, '0, 0, 0, '0, '0, '0, "R6 clear via alias");
    check("R6 l_irq low", BW'(l_irq_o), '0);
    step(1, 1, 6'd63, 16'h0999, 2'b11, 1, 0, 6'd15, '0, '0, "R12 set wins");
    check("R12 r_irq high", BW'(r_irq_o), 16'd1);
    step(1, 1, 6'd14, 16'h0111, 2'b11, 1, 1, 6'd14, 16'h0222, 2'b11, "R11 both write mailbox");
    step(1, 0, 6'd14, '0, '0, 1, 0, 6'd15, '0, '0, "R11/R12 readback");

    // R11: collisions on an ordinary word
    step(1, 1, 6'd5, 16'h0AAA, 2'b01, 1, 1, 6'd21, 16'h0555, 2'b11, "R11 lane merge");
    step(1, 1, 6'd5, 16'h0C3C, 2'b10, 1, 1, 6'd5, 16'h0FFF, 2'b01, "R11 disjoint lanes");
    step(1, 1, 6'd5, 16'h0123, 2'b11, 1, 0, 6'd5, '0, '0, "R11 right reads old");
    step(0, 0, '0, '0, '0, 1, 1, 6'd5, 16'h0DEF, 2'b11, "R11 setup");
    step(1, 0, 6'd37, '0, '0, 1, 1, 6'd5, 16'h0321, 2'b11, "R11 left reads old");
    step(1, 0, 6'd5, '0, '0, 1, 0, 6'd53, '0, '0, "R11 final");
    idle("R2 hold");
    check("R10 busy end", BW'(busy_o), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule